// File: doc/BRIEF.md
# Two-Word Accumulator Processor with Stepped Control

This block is a small processor with a single accumulator. It reads instructions from a synchronous, word-addressed memory. Every instruction takes two memory words. The first word is the opcode. The second word is the address of the operand. The only operation the machine performs is an accumulate: it adds the operand word to the accumulator. Any other opcode stops the machine, which then stays stopped until reset.

A hardwired step sequencer drives the datapath with one register transfer per clock. It has a program counter, a memory address register, a memory buffer register, an instruction register and the accumulator. Every transfer that changes a value goes through one ALU that supports eight operations, and this includes the program-counter increment. Only the capture of memory read data into the buffer register bypasses the ALU. Each step sets the ALU operation, chooses which register drives the ALU's first operand, and drives the load strobes of the registers and the memory enable and write strobes.

Top module: `acc_seq_cpu`

## Requirements
- R1: The ALU operation code is a 3-bit field that selects one of eight results.
  - 000: A+B
  - 001: A
  - 010: A+1
  - 011: A shifted left by one
  - 100: A-B
  - 101: the bitwise NOT of A
  - 110: A-1
  - 111: A shifted right by one

  Results are taken modulo 2^width, and the shifts bring in zeros.
- R2: While `rst_n` is low, the following hold:
  - the program counter and the accumulator are zero;
  - `halted` is low;
  - `mem_en` is low;
  - `mem_addr` is zero.

  The first rising edge after release starts the first fetch step at address 0.
- R3: Each instruction reads memory exactly three times, with one clock pulse of `mem_en` per read and never in two consecutive cycles. The reads go to the program counter value P, then to P+1, then to the address X held in word P+1. `mem_addr` always shows the memory address register.
- R4: The program counter advances by exactly one for each word fetched. It wraps from 2^ADDR_W-1 to 0.
- R5: When the opcode word equals `OP_ADD` (default 0x0001), the accumulator becomes (ACC + memory[X]) mod 2^DATA_W. The new value appears after the 13th rising edge of the instruction. The accumulator is unchanged after the 12th rising edge.
- R6: An add instruction occupies exactly 13 clock steps. The next opcode fetch starts in the following step.
- R7: An opcode word that differs from `OP_ADD` in any bit raises `halted` after the 6th rising edge of that instruction. From then on the following hold until reset:
  - `halted` stays high;
  - no further memory access takes place;
  - the accumulator holds its value.
- R8: `mem_we` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_en | output | 1 | Memory access strobe; read data returns on the next cycle |
| mem_we | output | 1 | Memory write strobe (held low) |
| mem_addr | output | ADDR_W | Word address, taken from the memory address register |
| mem_wdata | output | DATA_W | Write data, taken from the memory buffer register |
| mem_rdata | input | DATA_W | Read data from the synchronous memory |
| acc | output | DATA_W | Accumulator contents |
| halted | output | 1 | High once an unknown opcode has been fetched |

## Verification
The assertions check several properties on every cycle:
- the write strobe stays low;
- memory reads are never back to back;
- the program counter moves only in steps of plus one;
- the accumulator changes only three cycles after a read;
- once halted, the machine stays halted, quiet and with a frozen accumulator.

Other behaviour needs the bench's scenarios. These cover:
- the values the accumulator reaches, including carry-out wrap;
- the exact step at which the accumulator changes;
- the read-address order within each instruction;
- operand addresses that point into code;
- program-counter wrap after 128 instructions;
- the full-word opcode compare;
- recovery after a reset in the middle of a run.

The ALU is swept over every operation and operand pair at width four.

// File: rtl/acc_cpu_pkg.sv
// Shared types for the accumulator processor: ALU operation codes,
// first-operand source select, sequencer steps and the control word.
package acc_cpu_pkg;

    typedef enum logic [2:0] {
        FN_ADD  = 3'b000,
        FN_PASS = 3'b001,
        FN_INC  = 3'b010,
        FN_SHL  = 3'b011,
        FN_SUB  = 3'b100,
        FN_NOT  = 3'b101,
        FN_DEC  = 3'b110,
        FN_SHR  = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PC   = 2'd1,
        SRC_MBR  = 2'd2,
        SRC_ACC  = 2'd3
    } src_e;

    typedef enum logic [3:0] {
        S_F_MAR = 4'd0,
        S_F_INC = 4'd1,
        S_F_RD  = 4'd2,
        S_F_MBR = 4'd3,
        S_F_IR  = 4'd4,
        S_A_MAR = 4'd5,
        S_A_INC = 4'd6,
        S_A_RD  = 4'd7,
        S_A_MBR = 4'd8,
        S_A_MOV = 4'd9,
        S_X_RD  = 4'd10,
        S_X_MBR = 4'd11,
        S_X_ADD = 4'd12,
        S_HALT  = 4'd13
    } step_e;

    typedef struct packed {
        src_e    a_src;
        alu_fn_e fn;
        logic    ld_mar;
        logic    ld_pc;
        logic    ld_mbr;
        logic    ld_ir;
        logic    ld_acc;
        logic    mem_en;
        logic    mem_we;
    } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
// Eight-operation ALU. Purely combinational.
// Assumes W >= 1. Every result is truncated to W bits, and the shifts bring in zeros.
module acc_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] c
);

    localparam logic [W-1:0] ONE = W'(1);

    // Select the result for the requested operation code.
    always_comb begin
        unique case (fn)
            FN_ADD:  c = a + b;
            FN_PASS: c = a;
            FN_INC:  c = a + ONE;
            FN_SHL:  c = a << 1;
            FN_SUB:  c = a - b;
            FN_NOT:  c = ~a;
            FN_DEC:  c = a - ONE;
            FN_SHR:  c = a >> 1;
            default: c = a;
        endcase
    end

endmodule

// File: rtl/acc_seq.sv
// Hardwired step sequencer. It issues one control word per clock.
// The opcode is checked in the first operand step. Any value other than
// OP_ADD sends the sequencer to a terminal halt step, which only reset leaves.
module acc_seq
    import acc_cpu_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter logic [DATA_W-1:0] OP_ADD = DATA_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ir,
    output ctrl_t             ctrl,
    output logic              halted
);

    step_e step_q;
    step_e step_d;

    // Advance the step register; reset returns to the first fetch step.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= S_F_MAR;
        else        step_q <= step_d;
    end

    // Decode the current step into strobes and the next step.
    always_comb begin
        ctrl.a_src  = SRC_NONE;
        ctrl.fn     = FN_PASS;
        ctrl.ld_mar = 1'b0;
        ctrl.ld_pc  = 1'b0;
        ctrl.ld_mbr = 1'b0;
        ctrl.ld_ir  = 1'b0;
        ctrl.ld_acc = 1'b0;
        ctrl.mem_en = 1'b0;
        ctrl.mem_we = 1'b0;
        step_d      = step_q;
        unique case (step_q)
            S_F_MAR: begin
                ctrl.a_src  = SRC_PC;
                ctrl.ld_mar = 1'b1;
                step_d      = S_F_INC;
            end
            S_F_INC: begin
                ctrl.a_src = SRC_PC;
                ctrl.fn    = FN_INC;
                ctrl.ld_pc = 1'b1;
                step_d     = S_F_RD;
            end
            S_F_RD: begin
                ctrl.mem_en = 1'b1;
                step_d      = S_F_MBR;
            end
            S_F_MBR: begin
                ctrl.ld_mbr = 1'b1;
                step_d      = S_F_IR;
            end
            S_F_IR: begin
                ctrl.a_src = SRC_MBR;
                ctrl.ld_ir = 1'b1;
                step_d     = S_A_MAR;
            end
            S_A_MAR: begin
                if (ir == OP_ADD) begin
                    ctrl.a_src  = SRC_PC;
                    ctrl.ld_mar = 1'b1;
                    step_d      = S_A_INC;
                end else begin
                    step_d = S_HALT;
                end
            end
            S_A_INC: begin
                ctrl.a_src = SRC_PC;
                ctrl.fn    = FN_INC;
                ctrl.ld_pc = 1'b1;
                step_d     = S_A_RD;
            end
            S_A_RD: begin
                ctrl.mem_en = 1'b1;
                step_d      = S_A_MBR;
            end
            S_A_MBR: begin
                ctrl.ld_mbr = 1'b1;
                step_d      = S_A_MOV;
            end
            S_A_MOV: begin
                ctrl.a_src  = SRC_MBR;
                ctrl.ld_mar = 1'b1;
                step_d      = S_X_RD;
            end
            S_X_RD: begin
                ctrl.mem_en = 1'b1;
                step_d      = S_X_MBR;
            end
            S_X_MBR: begin
                ctrl.ld_mbr = 1'b1;
                step_d      = S_X_ADD;
            end
            S_X_ADD: begin
                ctrl.a_src  = SRC_ACC;
                ctrl.fn     = FN_ADD;
                ctrl.ld_acc = 1'b1;
                step_d      = S_F_MAR;
            end
            default: step_d = S_HALT;
        endcase
    end

    assign halted = (step_q == S_HALT);

endmodule

// File: rtl/acc_regs.sv
// Register file of the processor: PC, MAR, MBR, IR and ACC, plus the mux
// that chooses the first ALU operand. Every register except MBR loads
// from the ALU output; MBR loads from memory read data.
// Assumes DATA_W >= ADDR_W, so the address registers take the low bits.
module acc_regs
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] alu_c,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] a_bus,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mbr_q,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] acc_q
);

    // Drive the first ALU operand from the selected register.
    always_comb begin
        unique case (ctrl.a_src)
            SRC_PC:  a_bus = DATA_W'(pc_q);
            SRC_MBR: a_bus = mbr_q;
            SRC_ACC: a_bus = acc_q;
            default: a_bus = '0;
        endcase
    end

    // Load the address registers from the ALU result under their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
        end else begin
            if (ctrl.ld_pc)  pc_q  <= alu_c[ADDR_W-1:0];
            if (ctrl.ld_mar) mar_q <= alu_c[ADDR_W-1:0];
        end
    end

    // Load the data registers: MBR from memory, IR and ACC from the ALU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
        end else begin
            if (ctrl.ld_mbr) mbr_q <= mem_rdata;
            if (ctrl.ld_ir)  ir_q  <= alu_c;
            if (ctrl.ld_acc) acc_q <= alu_c;
        end
    end

endmodule

// File: rtl/acc_seq_cpu.sv
// Top level of the accumulator processor. Connects the sequencer, the
// register file and the ALU. The memory is external and synchronous:
// read data arrives on the cycle after mem_en.
module acc_seq_cpu
    import acc_cpu_pkg::*;
#(
    parameter int                DATA_W = 16,
    parameter int                ADDR_W = 8,
    parameter logic [DATA_W-1:0] OP_ADD = DATA_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc,
    output logic              halted
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] a_bus;
    logic [DATA_W-1:0] alu_c;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mbr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;

    acc_seq #(.DATA_W(DATA_W), .OP_ADD(OP_ADD)) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir     (ir_q),
        .ctrl   (ctrl),
        .halted (halted)
    );

    acc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .alu_c     (alu_c),
        .mem_rdata (mem_rdata),
        .a_bus     (a_bus),
        .pc_q      (pc_q),
        .mar_q     (mar_q),
        .mbr_q     (mbr_q),
        .ir_q      (ir_q),
        .acc_q     (acc_q)
    );

    acc_alu #(.W(DATA_W)) i_alu (
        .a  (a_bus),
        .b  (mbr_q),
        .fn (ctrl.fn),
        .c  (alu_c)
    );

    assign mem_en    = ctrl.mem_en;
    assign mem_we    = ctrl.mem_we;
    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign acc       = acc_q;

endmodule

// File: rtl/acc_seq_cpu_chk.sv
// Checker for the accumulator processor, attached to the top level by bind.
// It watches the memory strobes, the halt flag, the accumulator and the
// program counter.
module acc_seq_cpu_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_en,
    input logic              mem_we,
    input logic              halted,
    input logic [DATA_W-1:0] acc,
    input logic [ADDR_W-1:0] pc_q
);

    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we); // R8

    AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n) mem_en |=> !mem_en); // R3

    AST_PC_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q != $past(pc_q)) |-> (pc_q == ADDR_W'($past(pc_q) + 1'b1))); // R4

    AST_ACC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != $past(acc)) |-> $past(mem_en, 3)); // R5

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R7

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !mem_en); // R7

    AST_HALT_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(acc)); // R7

endmodule

bind acc_seq_cpu acc_seq_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_en (mem_en),
    .mem_we (mem_we),
    .halted (halted),
    .acc    (acc),
    .pc_q   (pc_q)
);

// File: tb/test_acc_seq_cpu.sv
`timescale 1ns/1ps
// Self-checking bench. It sweeps the ALU exhaustively at width 4 and runs
// three programs on the processor, using a synchronous memory model
// that lives in the bench.
module test_acc_seq_cpu;
    import acc_cpu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_en, mem_we, halted;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata, acc;
    logic [15:0] mem [0:255];

    int n_tests = 0;
    int n_fail  = 0;
    int exp_addr [0:511];
    int n_exp   = 0;
    int rd_idx  = 0;

    logic [3:0] ua, ub, uc;
    alu_fn_e    ufn;

    always #2 clk = ~clk;

    acc_seq_cpu i_acc_seq_cpu (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc(acc), .halted(halted)
    );

    acc_alu #(.W(4)) i_alu (.a(ua), .b(ub), .fn(ufn), .c(uc));

    // Synchronous memory model: read data returns on the cycle after mem_en.
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= mem[mem_addr];
            if (mem_we) mem[mem_addr] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Read-order monitor: compares each memory access with the expected address list.
    always @(negedge clk) begin
        if (!rst_n) rd_idx = 0;
        else if (mem_en) begin
            if (rd_idx < n_exp)
                chk(mem_addr == 8'(exp_addr[rd_idx]), "R3 read address", mem_addr, exp_addr[rd_idx]);
            else
                chk(1'b0, "R7 unexpected read", mem_addr, -1);
            chk(mem_we == 1'b0, "R8 write strobe", mem_we, 0);
            rd_idx++;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic run_add(input logic [15:0] exp_acc, input logic [15:0] prev_acc, input bit timing);
        repeat (12) @(posedge clk);
        @(negedge clk);
        if (timing) chk(acc == prev_acc, "R5 acc held before step 13", acc, prev_acc);
        @(posedge clk);
        @(negedge clk);
        chk(acc == exp_acc, "R5/R6 acc after add", acc, exp_acc);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(acc == 16'h0 && halted == 1'b0, "R2 reset acc/halted", {acc, 7'b0, halted}, 0);
        chk(mem_en == 1'b0 && mem_addr == 8'h00, "R2 reset memory port", {mem_en, mem_addr}, 0);
    endtask

    localparam logic [7:0] XS [0:5] = '{8'h80, 8'h81, 8'h80, 8'h82, 8'h83, 8'h01};

    initial begin
        logic [15:0] sum;
        logic [15:0] held;
        int          e;

        // R1: exhaustive ALU sweep at width 4.
        for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    ufn = alu_fn_e'(f);
                    ua  = 4'(a);
                    ub  = 4'(b);
                    #1;
                    case (f)
                        0: e = (a + b) & 15;
                        1: e = a;
                        2: e = (a + 1) & 15;
                        3: e = (a * 2) & 15;
                        4: e = (a - b) & 15;
                        5: e = 15 - a;
                        6: e = (a - 1) & 15;
                        default: e = a / 2;
                    endcase
                    chk(uc == 4'(e), "R1 alu result", uc, e);
                end
            end
        end

        // Program 1: six adds, one of which reads a code word, then an opcode that differs in its high bit.
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        for (int k = 0; k < 6; k++) begin
            mem[2*k]   = 16'h0001;
            mem[2*k+1] = {8'h00, XS[k]};
        end
        mem[12]   = 16'h8001;
        mem[8'h80] = 16'h1234;
        mem[8'h81] = 16'hFFFF;
        mem[8'h82] = 16'h8000;
        mem[8'h83] = 16'h7FFF;
        n_exp = 0;
        for (int k = 0; k < 6; k++) begin
            exp_addr[n_exp] = 2*k; exp_addr[n_exp+1] = 2*k+1; exp_addr[n_exp+2] = XS[k];
            n_exp += 3;
        end
        exp_addr[n_exp] = 12; n_exp++;

        do_reset();
        rst_n = 1'b1;
        sum = 16'h0;
        for (int k = 0; k < 6; k++) begin
            held = sum;
            sum  = sum + mem[XS[k]];
            run_add(sum, held, 1'b1);
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(halted == 1'b0, "R7 not halted before step 6", halted, 0);
        @(posedge clk);
        @(negedge clk);
        chk(halted == 1'b1, "R7 halted after step 6", halted, 1);
        repeat (20) @(negedge clk);
        chk(halted == 1'b1, "R7 halt sticky", halted, 1);
        chk(acc == sum, "R7 acc held while halted", acc, sum);
        chk(rd_idx == n_exp, "R3/R7 read count", rd_idx, n_exp);

        // Program 2: reset in the middle of a halt, then an unknown opcode at address 0.
        do_reset();
        mem[0] = 16'h0002;
        n_exp = 1; exp_addr[0] = 0;
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(halted == 1'b1 && acc == 16'h0, "R2/R7 restart then halt", {halted, acc}, 17'h10000);
        chk(rd_idx == 1, "R2 first read at address 0", rd_idx, 1);

        // Program 3: the whole memory is add instructions, so the program counter wraps.
        for (int i = 0; i < 256; i++) mem[i] = (i % 2 == 0) ? 16'h0001 : 16'h0001;
        do_reset();
        n_exp = 0;
        for (int k = 0; k < 130; k++) begin
            exp_addr[n_exp] = (2*k) % 256; exp_addr[n_exp+1] = (2*k+1) % 256; exp_addr[n_exp+2] = 1;
            n_exp += 3;
        end
        rst_n = 1'b1;
        for (int k = 0; k < 130; k++) begin
            held = 16'(k);
            run_add(16'(k + 1), held, (k == 127 || k == 128));
        end
        chk(acc == 16'd130, "R4 acc after wrap", acc, 130);
        chk(rd_idx == 390, "R4 reads across wrap", rd_idx, 390);
        chk(halted == 1'b0, "R4 running after wrap", halted, 0);
        do_reset();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule